// File: doc/BRIEF.md
# YUV 4:4:4 to 4:2:2 Pixel Formatter

This block takes one YUV pixel per transfer and re-emits it either as a full three-component pixel, or as a two-bus 4:2:2 stream. In the 4:2:2 form, luma stays on its own bus and a single chroma bus carries U and V on alternate pixels. Each chroma pair is taken from the even pixel of a pixel pair. It is either smoothed by a three-tap low-pass filter or taken as is, with the odd pixel's chroma thrown away. A line-start pulse latches the three mode inputs for the next line and restarts the chroma phase.

Both data sides are valid/ready streams. An input beat transfers on a clock where `s_valid` and `s_ready` are both high. An output beat transfers where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, the output beat and its data stay frozen. `s_ready` never depends on `s_valid`, but it does follow `m_ready` in the same cycle.

The filter looks one pixel ahead, so a pixel is released when its successor arrives. A pixel is also released one cycle after acceptance if it carries the end-of-line flag. Every line must therefore end with `s_eol`.

Top module: `yfmt_formatter`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1. The latched modes are 0 (4:4:4, U first, filtered) until the first line-start pulse, whatever the mode inputs show.
- R2: `cfg_422`, `cfg_v_first` and `cfg_drop` are latched by a `line_start` pulse, or together with the pixel accepted in the same cycle as that pulse. The latched values govern the whole line, and changing the inputs mid-line has no effect on it.
- R3: With `cfg_422`=0, each output beat carries the pixel's Y on `m_luma`, U on `m_chroma_a` and V on `m_chroma_b`, all unmodified.
- R4: With `cfg_422`=1, `m_luma` carries Y and `m_chroma_b` is 0. On a pixel of even phase (phase 0), `m_chroma_a` carries the first chroma component. On a pixel of odd phase (phase 1), it carries the second component. Both components are computed at the preceding even pixel.
- R5: With `cfg_v_first`=0, U is the first component and V the second. With `cfg_v_first`=1, V is first and U second.
- R6: The phase is 0 for the first pixel accepted after a `line_start` pulse, or for the pixel accepted in the same cycle as the pulse. The phase toggles on every accepted pixel and is not reset by `s_eol`.
- R7: With `cfg_drop`=0, each chroma component is computed as (prev + 2*cur + next + 2) >> 2. At the first pixel of a line, prev is replaced by the current sample. At a pixel flagged `s_eol`, next is replaced by the current sample.
- R8: With `cfg_drop`=1, the even pixel's U and V pass unfiltered, and the chroma of odd-phase pixels never reaches the output.
- R9: With `m_ready` held at 1 and pixels presented back to back, each pixel appears at the output two clocks after the cycle in which it was accepted, in every mode.
- R10: While the output is stalled, its data holds and `s_ready` drops once a pixel is waiting. No pixel is lost, duplicated or reordered under any pattern of `m_ready` and input gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_422 | input | 1 | 1 selects 4:2:2 output, 0 selects 4:4:4 |
| cfg_v_first | input | 1 | 1 puts V on even-phase pixels |
| cfg_drop | input | 1 | 1 drops odd chroma, 0 filters |
| line_start | input | 1 | pulse marking the start of a new line |
| s_valid | input | 1 | input pixel valid |
| s_ready | output | 1 | input pixel accepted when high with s_valid |
| s_y | input | 8 | input luma |
| s_u | input | 8 | input U chroma |
| s_v | input | 8 | input V chroma |
| s_eol | input | 1 | input pixel is the last of its line |
| m_valid | output | 1 | output beat valid |
| m_ready | input | 1 | downstream accepts output beat |
| m_luma | output | 8 | output luma |
| m_chroma_a | output | 8 | U in 4:4:4, alternating chroma in 4:2:2 |
| m_chroma_b | output | 8 | V in 4:4:4, zero in 4:2:2 |

## Verification
The hardest situation to reach is a pixel that has already been accepted while the output stage is stalled. In that state, its right-hand filter neighbour arrives during the stall and must wait with it. To get there, the stimulus toggles `m_ready` at random and inserts random input gaps across lines of every mode. The phase continuation across a line with no start pulse is reached by sending a line of odd length followed by a line without `line_start`. The right-edge replication is reached by giving some lines an odd length.

// File: rtl/yfmt_pkg.sv
package yfmt_pkg;
  // Per-line operating mode, latched at line start.
  typedef struct packed {
    logic pack422;
    logic v_first;
    logic drop;
  } mode_t;

  localparam int unsigned NCHROMA = 2;  // index 0 = U, index 1 = V
endpackage

// File: rtl/yfmt_line_ctl.sv
// Tags each accepted pixel with its line-start flag, chroma phase and mode.
module yfmt_line_ctl
  import yfmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_start,
  input  mode_t cfg_in,
  input  logic  acc,
  output logic  tag_sol,
  output logic  tag_odd,
  output mode_t tag_mode
);
  logic  sol_pend;
  mode_t pend_mode;
  mode_t act_mode;
  logic  next_odd;

  always_comb begin
    tag_sol = line_start | sol_pend;
    if (line_start)    tag_mode = cfg_in;
    else if (sol_pend) tag_mode = pend_mode;
    else               tag_mode = act_mode;
    tag_odd = tag_sol ? 1'b0 : next_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sol_pend  <= 1'b0;
      pend_mode <= '0;
      act_mode  <= '0;
      next_odd  <= 1'b0;
    end else if (acc) begin
      sol_pend <= 1'b0;
      act_mode <= tag_mode;
      next_odd <= ~tag_odd;
    end else if (line_start) begin
      sol_pend  <= 1'b1;
      pend_mode <= cfg_in;
    end
  end
endmodule

// File: rtl/yfmt_window.sv
// One-pixel look-ahead window: holds the current pixel until its right
// neighbour arrives (or it is flagged end-of-line), and remembers the
// previous chroma for the left tap.
module yfmt_window
  import yfmt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  input  logic [W-1:0]               s_y,
  input  logic [NCHROMA-1:0][W-1:0]  s_c,
  input  logic                       s_eol,
  input  logic                       tag_sol,
  input  logic                       tag_odd,
  input  mode_t                      tag_mode,
  input  logic                       adv,
  output logic                       s_ready,
  output logic                       acc,
  output logic                       rel,
  output logic [W-1:0]               cur_y,
  output logic [NCHROMA-1:0][W-1:0]  cur_c,
  output logic [NCHROMA-1:0][W-1:0]  prv_c,
  output logic [NCHROMA-1:0][W-1:0]  nxt_c,
  output logic                       cur_odd,
  output mode_t                      cur_mode
);
  logic                      h_v;
  logic [W-1:0]              h_y;
  logic [NCHROMA-1:0][W-1:0] h_c;
  logic                      h_sol;
  logic                      h_last;
  logic                      h_odd;
  mode_t                     h_mode;
  logic [NCHROMA-1:0][W-1:0] p_c;

  assign s_ready = !h_v || adv;
  assign acc     = s_valid && s_ready;
  assign rel     = h_v && adv && (h_last || s_valid);

  assign cur_y    = h_y;
  assign cur_c    = h_c;
  assign cur_odd  = h_odd;
  assign cur_mode = h_mode;

  for (genvar g = 0; g < NCHROMA; g++) begin : g_taps
    assign prv_c[g] = h_sol  ? h_c[g] : p_c[g];
    assign nxt_c[g] = h_last ? h_c[g] : s_c[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_v    <= 1'b0;
      h_y    <= '0;
      h_c    <= '0;
      h_sol  <= 1'b0;
      h_last <= 1'b0;
      h_odd  <= 1'b0;
      h_mode <= '0;
    end else if (acc) begin
      h_v    <= 1'b1;
      h_y    <= s_y;
      h_c    <= s_c;
      h_sol  <= tag_sol;
      h_last <= s_eol;
      h_odd  <= tag_odd;
      h_mode <= tag_mode;
    end else if (rel) begin
      h_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   p_c <= '0;
    else if (rel) p_c <= h_c;
  end

  // Checker state: phase of the last released pixel.
  logic seen_rel;
  logic last_rel_odd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_rel     <= 1'b0;
      last_rel_odd <= 1'b0;
    end else if (rel) begin
      seen_rel     <= 1'b1;
      last_rel_odd <= h_odd;
    end
  end

  // R10: an accepted pixel is held in the window on the next cycle.
  a_r10_accept_lands: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> h_v);

  // R6: pixels leave the window with alternating phase unless a line restarts.
  a_r6_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    rel && !h_sol && seen_rel |-> h_odd != last_rel_odd);

  // R6: a line's first pixel always carries phase 0.
  a_r6_sol_even: assert property (@(posedge clk) disable iff (!rst_n)
    rel && h_sol |-> !h_odd);
endmodule

// File: rtl/yfmt_chroma.sv
// Per-component chroma decimation: [1,2,1]/4 with rounding, or pass-through.
module yfmt_chroma
  import yfmt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      drop,
  input  logic [NCHROMA-1:0][W-1:0] prv_c,
  input  logic [NCHROMA-1:0][W-1:0] cur_c,
  input  logic [NCHROMA-1:0][W-1:0] nxt_c,
  output logic [NCHROMA-1:0][W-1:0] res_c
);
  localparam int unsigned SW = W + 2;

  for (genvar g = 0; g < NCHROMA; g++) begin : g_comp
    logic [SW-1:0] sum;
    logic [W-1:0]  lo;
    logic [W-1:0]  hi;

    always_comb begin
      sum = {2'b00, prv_c[g]} + {1'b0, cur_c[g], 1'b0} + {2'b00, nxt_c[g]} + SW'(2);
      res_c[g] = drop ? cur_c[g] : sum[SW-1:2];
    end

    always_comb begin
      lo = cur_c[g];
      hi = cur_c[g];
      if (prv_c[g] < lo) lo = prv_c[g];
      if (nxt_c[g] < lo) lo = nxt_c[g];
      if (prv_c[g] > hi) hi = prv_c[g];
      if (nxt_c[g] > hi) hi = nxt_c[g];
    end

    // R7: a low-pass result never leaves the range of its taps.
    a_r7_within_taps: assert property (@(posedge clk) disable iff (!rst_n)
      en && !drop |-> (res_c[g] >= lo) && (res_c[g] <= hi));
  end
endmodule

// File: rtl/yfmt_out.sv
// Output stage: packs into 4:4:4 or 4:2:2 and holds under back-pressure.
module yfmt_out
  import yfmt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rel,
  input  logic [W-1:0]              cur_y,
  input  logic [NCHROMA-1:0][W-1:0] cur_c,
  input  logic [NCHROMA-1:0][W-1:0] dec_c,
  input  logic                      cur_odd,
  input  mode_t                     cur_mode,
  input  logic                      m_ready,
  output logic                      adv,
  output logic                      m_valid,
  output logic [W-1:0]              m_luma,
  output logic [W-1:0]              m_chroma_a,
  output logic [W-1:0]              m_chroma_b
);
  logic [W-1:0] stash;
  logic [W-1:0] first_c;
  logic [W-1:0] second_c;

  assign adv = !m_valid || m_ready;

  always_comb begin
    first_c  = cur_mode.v_first ? dec_c[1] : dec_c[0];
    second_c = cur_mode.v_first ? dec_c[0] : dec_c[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid    <= 1'b0;
      m_luma     <= '0;
      m_chroma_a <= '0;
      m_chroma_b <= '0;
      stash      <= '0;
    end else if (adv) begin
      m_valid <= rel;
      if (rel) begin
        m_luma <= cur_y;
        if (!cur_mode.pack422) begin
          m_chroma_a <= cur_c[0];
          m_chroma_b <= cur_c[1];
        end else if (!cur_odd) begin
          m_chroma_a <= first_c;
          m_chroma_b <= '0;
          stash      <= second_c;
        end else begin
          m_chroma_a <= stash;
          m_chroma_b <= '0;
        end
      end
    end
  end

  // R10: a stalled output beat keeps its valid and data.
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_luma) && $stable(m_chroma_a)
                            && $stable(m_chroma_b));
endmodule

// File: rtl/yfmt_formatter.sv
module yfmt_formatter
  import yfmt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_422,
  input  logic         cfg_v_first,
  input  logic         cfg_drop,
  input  logic         line_start,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_y,
  input  logic [W-1:0] s_u,
  input  logic [W-1:0] s_v,
  input  logic         s_eol,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_luma,
  output logic [W-1:0] m_chroma_a,
  output logic [W-1:0] m_chroma_b
);
  mode_t                     cfg_in;
  logic                      acc;
  logic                      rel;
  logic                      adv;
  logic                      tag_sol;
  logic                      tag_odd;
  mode_t                     tag_mode;
  logic [NCHROMA-1:0][W-1:0] s_c;
  logic [W-1:0]              cur_y;
  logic [NCHROMA-1:0][W-1:0] cur_c;
  logic [NCHROMA-1:0][W-1:0] prv_c;
  logic [NCHROMA-1:0][W-1:0] nxt_c;
  logic [NCHROMA-1:0][W-1:0] dec_c;
  logic                      cur_odd;
  mode_t                     cur_mode;

  assign cfg_in = '{pack422: cfg_422, v_first: cfg_v_first, drop: cfg_drop};
  assign s_c    = {s_v, s_u};

  yfmt_line_ctl u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_start(line_start),
    .cfg_in   (cfg_in),
    .acc      (acc),
    .tag_sol  (tag_sol),
    .tag_odd  (tag_odd),
    .tag_mode (tag_mode)
  );

  yfmt_window #(.W(W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_y      (s_y),
    .s_c      (s_c),
    .s_eol    (s_eol),
    .tag_sol  (tag_sol),
    .tag_odd  (tag_odd),
    .tag_mode (tag_mode),
    .adv      (adv),
    .s_ready  (s_ready),
    .acc      (acc),
    .rel      (rel),
    .cur_y    (cur_y),
    .cur_c    (cur_c),
    .prv_c    (prv_c),
    .nxt_c    (nxt_c),
    .cur_odd  (cur_odd),
    .cur_mode (cur_mode)
  );

  yfmt_chroma #(.W(W)) u_chroma (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (rel && cur_mode.pack422 && !cur_odd),
    .drop  (cur_mode.drop),
    .prv_c (prv_c),
    .cur_c (cur_c),
    .nxt_c (nxt_c),
    .res_c (dec_c)
  );

  yfmt_out #(.W(W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rel        (rel),
    .cur_y      (cur_y),
    .cur_c      (cur_c),
    .dec_c      (dec_c),
    .cur_odd    (cur_odd),
    .cur_mode   (cur_mode),
    .m_ready    (m_ready),
    .adv        (adv),
    .m_valid    (m_valid),
    .m_luma     (m_luma),
    .m_chroma_a (m_chroma_a),
    .m_chroma_b (m_chroma_b)
  );
endmodule

// File: tb/tb_yfmt_formatter.sv
module tb_yfmt_formatter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_422 = 1'b0, cfg_v_first = 1'b0, cfg_drop = 1'b0;
  logic       line_start = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_y = '0, s_u = '0, s_v = '0;
  logic       s_eol = 1'b0;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_luma, m_chroma_a, m_chroma_b;

  always #5 clk = ~clk;

  yfmt_formatter dut (
    .clk(clk), .rst_n(rst_n), .cfg_422(cfg_422), .cfg_v_first(cfg_v_first),
    .cfg_drop(cfg_drop), .line_start(line_start), .s_valid(s_valid),
    .s_ready(s_ready), .s_y(s_y), .s_u(s_u), .s_v(s_v), .s_eol(s_eol),
    .m_valid(m_valid), .m_ready(m_ready), .m_luma(m_luma),
    .m_chroma_a(m_chroma_a), .m_chroma_b(m_chroma_b)
  );

  typedef struct {
    logic [7:0] y;
    logic [7:0] a;
    logic [7:0] b;
    int         ecyc;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   bp = 1'b0;
  bit   finished = 1'b0;

  // Bench-side model state.
  bit         bm_422 = 0, bm_vf = 0, bm_drop = 0;
  bit         ph = 0;
  logic [7:0] pu = '0, pv = '0, stash_c = '0;
  logic [7:0] ly[16], lu[16], lv[16];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] f121(input logic [7:0] p, input logic [7:0] c,
                                      input logic [7:0] n);
    int s;
    s = int'(p) + 2 * int'(c) + int'(n) + 2;
    return 8'(s / 4);
  endfunction

  // Monitor / scoreboard.
  always @(negedge clk) begin
    m_ready = bp ? 1'($urandom_range(0, 1)) : 1'b1;
    if (rst_n && m_valid && m_ready) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10: unexpected beat got %h/%h/%h exp none",
                 m_luma, m_chroma_a, m_chroma_b);
      end else begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (m_luma !== e.y || m_chroma_a !== e.a || m_chroma_b !== e.b) begin
          bad++;
          $display("FAIL %s: data got %h/%h/%h exp %h/%h/%h", e.tag,
                   m_luma, m_chroma_a, m_chroma_b, e.y, e.a, e.b);
        end
        if (e.ecyc >= 0) begin
          total++;
          if (cyc != e.ecyc) begin
            bad++;
            $display("FAIL R9: latency cycle got %0d exp %0d", cyc, e.ecyc);
          end
        end
      end
    end
  end

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic drive_px(input logic [7:0] y, input logic [7:0] u,
                          input logic [7:0] v, input bit eol, input bit ls,
                          output int acc_cyc);
    s_valid = 1'b1; s_y = y; s_u = u; s_v = v; s_eol = eol; line_start = ls;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    acc_cyc = cyc;
    @(negedge clk);
    s_valid = 1'b0; s_eol = 1'b0; line_start = 1'b0;
  endtask

  task automatic fill(input int len, input bit extreme);
    for (int i = 0; i < len; i++) begin
      ly[i] = 8'($urandom); lu[i] = 8'($urandom); lv[i] = 8'($urandom);
    end
    if (extreme) begin
      lu[0] = 8'hFF; lu[1] = 8'h00; lv[0] = 8'h00; lv[1] = 8'hFF;
      lu[len-1] = 8'h01; lv[len-1] = 8'hFE;
    end
  endtask

  task automatic send_line(input int len, input bit ls_sep, input bit ls_with,
                           input bit cont, input bit flip_mid, input bit gaps,
                           input string tag);
    exp_t el[16];
    int   ac;
    if (ls_sep) begin
      bm_422 = cfg_422; bm_vf = cfg_v_first; bm_drop = cfg_drop;
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
    end
    if (ls_with) begin
      bm_422 = cfg_422; bm_vf = cfg_v_first; bm_drop = cfg_drop;
    end
    for (int i = 0; i < len; i++) begin
      bit sol;
      sol = (i == 0) && (ls_sep || ls_with);
      if (sol) ph = 0;
      el[i].y = ly[i];
      el[i].tag = tag;
      if (!bm_422) begin
        el[i].a = lu[i];
        el[i].b = lv[i];
      end else if (!ph) begin
        logic [7:0] fu, fv;
        if (bm_drop) begin
          fu = lu[i]; fv = lv[i];
        end else begin
          fu = f121(sol ? lu[i] : pu, lu[i], (i == len - 1) ? lu[i] : lu[i+1]);
          fv = f121(sol ? lv[i] : pv, lv[i], (i == len - 1) ? lv[i] : lv[i+1]);
        end
        el[i].a = bm_vf ? fv : fu;
        stash_c = bm_vf ? fu : fv;
        el[i].b = 8'h00;
      end else begin
        el[i].a = stash_c;
        el[i].b = 8'h00;
      end
      pu = lu[i]; pv = lv[i]; ph = !ph;
    end
    for (int i = 0; i < len; i++) begin
      if (flip_mid && i == 2) begin
        cfg_422 = ~cfg_422; cfg_v_first = ~cfg_v_first; cfg_drop = ~cfg_drop;
      end
      drive_px(ly[i], lu[i], lv[i], i == len - 1, ls_with && i == 0, ac);
      el[i].ecyc = cont ? ac + 2 : -1;
      q.push_back(el[i]);
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic set_cfg(input bit f, input bit vf, input bit d);
    cfg_422 = f; cfg_v_first = vf; cfg_drop = d;
  endtask

  task automatic drain;
    int n;
    n = 0;
    while (q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    total++;
    if (s_ready !== 1'b1 || m_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: reset got s_ready=%b m_valid=%b exp 1 0", s_ready, m_valid);
    end
    @(negedge clk);

    // R1: no line_start yet, so 4:4:4 applies despite the mode inputs.
    set_cfg(1, 1, 1); fill(5, 0);
    send_line(5, 0, 0, 1, 0, 0, "R1");
    // R3 + R9: plain 4:4:4 line.
    set_cfg(0, 0, 0); fill(6, 0);
    send_line(6, 1, 0, 1, 0, 0, "R3/R9");
    // R4 R5 R7 R9: 4:2:2, U first, filtered, even length, extremes for rounding.
    set_cfg(1, 0, 0); fill(6, 1);
    send_line(6, 0, 1, 1, 0, 0, "R4/R7/R9");
    // R5 R7: V first, odd length (right edge replicated on an even pixel).
    set_cfg(1, 1, 0); fill(7, 1);
    send_line(7, 1, 0, 1, 0, 0, "R5/R7");
    // R6: no line_start, phase carries over from the odd-length line.
    fill(4, 0);
    send_line(4, 0, 0, 1, 0, 0, "R6");
    // R6 + R8: restart with line_start, drop mode.
    set_cfg(1, 0, 1); fill(8, 0);
    send_line(8, 0, 1, 1, 0, 0, "R6/R8/R9");
    // R8: drop mode, V first, odd length.
    set_cfg(1, 1, 1); fill(5, 0);
    send_line(5, 1, 0, 1, 0, 0, "R5/R8");
    // R2: mode inputs change mid-line, no effect on this line.
    set_cfg(1, 0, 0); fill(9, 0);
    send_line(9, 1, 0, 1, 1, 0, "R2");
    // R2: the flipped inputs apply only after the next pulse.
    fill(6, 0);
    send_line(6, 1, 0, 1, 0, 0, "R2/R3");
    drain();

    // R10: random back-pressure and input gaps across all modes.
    bp = 1'b1;
    for (int k = 0; k < 16; k++) begin
      int len;
      len = 3 + (k % 8);
      set_cfg(1'(k % 3 != 0), 1'((k / 2) % 2), 1'((k / 4) % 2));
      fill(len, k % 5 == 0);
      send_line(len, k % 2 == 0, k % 2 == 1, 0, 0, 1, "R10");
    end
    drain();
    bp = 1'b0;
    repeat (4) @(negedge clk);

    total++;
    if (q.size() != 0 || m_valid !== 1'b0) begin
      bad++;
      $display("FAIL R10: drain got pending=%0d m_valid=%b exp 0 0", q.size(), m_valid);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule